// File: doc/BRIEF.md
# In-Place Resistive Majority Storage Array

This block is a word-addressed storage array that computes inside itself. Its only compute primitive takes three operands A, B and C and replaces the destination C with the majority of A, the inverted B, and the previous C. Per bit, the new value is `(A & ~B) | (~B & C) | (A & C)`. There is no result register. The result always lands in the destination location. Either of A and B may be a literal 0, a literal 1 or a stored location. Sequences of these operations build clears, copies, inversions and wider logic.

An operation is offered on a valid/ready strobe. The `op_bit_mode` pin picks how it applies:

- **Word mode** applies the primitive to every bit position of the addressed words at once.
- **Bit mode** picks one bit from each operand. Each operand has its own word address and bit offset, and only the destination bit is rewritten.

The array stalls the requester by holding `op_ready` low. It does this while an operation is being written back, and also while the direct host port is in use. A requester that sees `op_ready` low keeps its request steady until a cycle in which both valid and ready are high.

The direct host port gives single-cycle preload of words and registered readback of words. It works only while no operation is in flight.

Top module: `rma_array`

## Requirements
- R1: In word mode, every bit i of the destination word becomes `(A[i] & ~B[i]) | (~B[i] & C[i]) | (A[i] & C[i])`, using the values sampled when the operation was accepted.
- R2: The result is written only into the destination word `op_c_addr`; every other word keeps its value.
- R3: Each of `op_a_sel` and `op_b_sel` selects the operand source: 2'b00 is literal 0 (all bits), 2'b01 is literal 1 (all bits), 2'b10 or 2'b11 is the stored word (word mode) or stored bit (bit mode) at the operand's address.
- R4: An operation with A = literal 0 and B = literal 1 leaves the destination at 0 whatever it held before.
- R5: An operation with A = literal 1 on a destination that holds 0 leaves the complement of B there.
- R6: In bit mode (`op_bit_mode` = 1), the A bit is `word[op_a_addr][op_a_off]` and the B bit is `word[op_b_addr][op_b_off]`. Only bit `op_c_off` of word `op_c_addr` is rewritten, from the old value of that bit.
- R7: `op_ready` is `!busy && !host_en`. An operation is accepted on a clock edge where `op_valid && op_ready`. `busy` is high for exactly the one following cycle, during which the write-back happens. The result is readable from the cycle after that. A request while `op_ready` is low has no effect.
- R8: When A, B and the destination name the same location, all operands take the values held before the write-back.
- R9: With `busy` low, a host write (`host_en`, `host_we`) stores `host_wdata` at `host_addr` at the clock edge. A host read returns the word on `host_rdata`, with `host_rvalid` high, in the following cycle. Host requests while `busy` is high are ignored: nothing is written and `host_rvalid` stays low.
- R10: After reset, every word reads as 0 and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Array can accept an operation this cycle |
| op_bit_mode | input | 1 | 0 = word mode, 1 = bit mode |
| op_a_sel | input | 2 | Source of operand A (literal 0, literal 1, stored) |
| op_b_sel | input | 2 | Source of operand B (literal 0, literal 1, stored) |
| op_a_addr | input | ADDR_W | Word address of operand A |
| op_a_off | input | OFF_W | Bit offset of operand A (bit mode) |
| op_b_addr | input | ADDR_W | Word address of operand B |
| op_b_off | input | OFF_W | Bit offset of operand B (bit mode) |
| op_c_addr | input | ADDR_W | Word address of the destination |
| op_c_off | input | OFF_W | Bit offset of the destination (bit mode) |
| busy | output | 1 | Write-back cycle of an accepted operation |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | WORD_W | Host write data |
| host_rdata | output | WORD_W | Host read data |
| host_rvalid | output | 1 | `host_rdata` holds the word of a read request from the previous cycle |

## Verification
The bench builds the array with `WORD_W` = 8 and `DEPTH` = 4. With an 8-bit word, three fixed patterns (F0, CC, AA) cover all eight combinations of operand bits in a single word operation. The bench therefore sweeps all nine literal/stored selector pairs in word mode. In bit mode it sweeps every combination of the three bit offsets, which gives 512 operations. A depth of four leaves spare words for checking that writes stay on their target. It also lets the bench run the aliasing cases where all three operands name one word, and the cases where a host access competes with an operation.

// File: rtl/rma_pkg.sv
package rma_pkg;
  // Operand source codes; any code with bit 1 set means a stored operand
  localparam logic [1:0] SRC_ZERO = 2'b00;
  localparam logic [1:0] SRC_ONE  = 2'b01;
  localparam logic [1:0] SRC_MEM  = 2'b10;

  typedef enum logic {
    MODE_WORD = 1'b0,
    MODE_BIT  = 1'b1
  } rma_mode_e;
endpackage

// File: rtl/rma_storage.sv
module rma_storage #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic [ADDR_W-1:0] rd_addr_c,
  input  logic [ADDR_W-1:0] rd_addr_h,
  output logic [WORD_W-1:0] rd_data_a,
  output logic [WORD_W-1:0] rd_data_b,
  output logic [WORD_W-1:0] rd_data_c,
  output logic [WORD_W-1:0] rd_data_h
);
  logic [WORD_W-1:0] cells_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells_q[i] <= '0;
    end else if (wr_en) begin
      cells_q[wr_addr] <= wr_data;
    end
  end

  // Four combinational read ports: three operands and the host
  assign rd_data_a = cells_q[rd_addr_a];
  assign rd_data_b = cells_q[rd_addr_b];
  assign rd_data_c = cells_q[rd_addr_c];
  assign rd_data_h = cells_q[rd_addr_h];
endmodule

// File: rtl/rma_operand_sel.sv
module rma_operand_sel #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned OFF_W  = $clog2(WORD_W)
) (
  input  logic [1:0]        src_sel,
  input  logic              bit_mode,
  input  logic [OFF_W-1:0]  bit_off,
  input  logic [WORD_W-1:0] stored,
  output logic [WORD_W-1:0] operand
);
  import rma_pkg::*;

  // Bit mode replicates the chosen bit so the update stage stays bitwise
  always_comb begin
    if (src_sel[1]) begin
      operand = bit_mode ? {WORD_W{stored[bit_off]}} : stored;
    end else if (src_sel == SRC_ONE) begin
      operand = '1;
    end else begin
      operand = '0;
    end
  end
endmodule

// File: rtl/rma_cell_update.sv
module rma_cell_update #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned OFF_W  = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [WORD_W-1:0] old_c,
  input  logic              bit_mode,
  input  logic [OFF_W-1:0]  c_off,
  output logic [WORD_W-1:0] new_c
);
  logic [WORD_W-1:0] maj_bits;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    logic hit;
    assign maj_bits[i] = (opnd_a[i] & ~opnd_b[i]) |
                         (~opnd_b[i] & old_c[i])  |
                         (opnd_a[i] & old_c[i]);
    assign hit      = (c_off == OFF_W'(i));
    assign new_c[i] = (!bit_mode || hit) ? maj_bits[i] : old_c[i];
  end
endmodule

// File: rtl/rma_array.sv
module rma_array #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH),
  parameter int unsigned OFF_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_bit_mode,
  input  logic [1:0]        op_a_sel,
  input  logic [1:0]        op_b_sel,
  input  logic [ADDR_W-1:0] op_a_addr,
  input  logic [OFF_W-1:0]  op_a_off,
  input  logic [ADDR_W-1:0] op_b_addr,
  input  logic [OFF_W-1:0]  op_b_off,
  input  logic [ADDR_W-1:0] op_c_addr,
  input  logic [OFF_W-1:0]  op_c_off,
  output logic              busy,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_rvalid
);
  localparam int unsigned NUM_SRC = 2;

  logic              busy_q;
  logic              accept;
  logic              host_wr_ok;
  logic              host_rd_ok;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] rd_a, rd_b, rd_c, rd_h;
  logic [WORD_W-1:0] upd_word;

  // Operand sampling registers (captured at acceptance)
  logic [WORD_W-1:0] a_q, b_q, c_q;
  logic              bit_mode_q;
  logic [OFF_W-1:0]  c_off_q;
  logic [ADDR_W-1:0] c_addr_q;

  assign op_ready   = !busy_q && !host_en;
  assign accept     = op_valid && op_ready;
  assign busy       = busy_q;
  assign host_wr_ok = host_en && host_we && !busy_q;
  assign host_rd_ok = host_en && !host_we && !busy_q;

  assign wr_en   = busy_q || host_wr_ok;
  assign wr_addr = busy_q ? c_addr_q : host_addr;
  assign wr_data = busy_q ? upd_word : host_wdata;

  rma_storage #(
    .WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) storage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (op_a_addr),
    .rd_addr_b (op_b_addr),
    .rd_addr_c (op_c_addr),
    .rd_addr_h (host_addr),
    .rd_data_a (rd_a),
    .rd_data_b (rd_b),
    .rd_data_c (rd_c),
    .rd_data_h (rd_h)
  );

  // One selector per source operand
  logic [1:0]        src_sel  [NUM_SRC];
  logic [OFF_W-1:0]  src_off  [NUM_SRC];
  logic [WORD_W-1:0] src_word [NUM_SRC];
  logic [WORD_W-1:0] src_opnd [NUM_SRC];

  assign src_sel[0]  = op_a_sel;
  assign src_off[0]  = op_a_off;
  assign src_word[0] = rd_a;
  assign src_sel[1]  = op_b_sel;
  assign src_off[1]  = op_b_off;
  assign src_word[1] = rd_b;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rma_operand_sel #(.WORD_W(WORD_W), .OFF_W(OFF_W)) sel_i (
      .src_sel  (src_sel[s]),
      .bit_mode (op_bit_mode),
      .bit_off  (src_off[s]),
      .stored   (src_word[s]),
      .operand  (src_opnd[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      a_q        <= '0;
      b_q        <= '0;
      c_q        <= '0;
      bit_mode_q <= 1'b0;
      c_off_q    <= '0;
      c_addr_q   <= '0;
    end else begin
      busy_q <= accept;
      if (accept) begin
        a_q        <= src_opnd[0];
        b_q        <= src_opnd[1];
        c_q        <= rd_c;
        bit_mode_q <= op_bit_mode;
        c_off_q    <= op_c_off;
        c_addr_q   <= op_c_addr;
      end
    end
  end

  rma_cell_update #(.WORD_W(WORD_W), .OFF_W(OFF_W)) update_i (
    .opnd_a   (a_q),
    .opnd_b   (b_q),
    .old_c    (c_q),
    .bit_mode (bit_mode_q),
    .c_off    (c_off_q),
    .new_c    (upd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd_ok;
      if (host_rd_ok) host_rdata <= rd_h;
    end
  end
endmodule

// File: rtl/rma_array_chk.sv
module rma_array_chk #(
  parameter int unsigned WORD_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic              op_bit_mode,
  input logic [1:0]        op_a_sel,
  input logic [1:0]        op_b_sel,
  input logic              busy,
  input logic              host_en,
  input logic              host_we,
  input logic              host_rvalid,
  input logic              upd_bit_mode,
  input logic [WORD_W-1:0] upd_word,
  input logic [WORD_W-1:0] old_word
);
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> busy);

  p_busy_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_no_ready_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_ready);

  p_clear_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !op_bit_mode && op_a_sel == 2'b00 && op_b_sel == 2'b01)
      |=> (upd_word == '0));

  p_single_bit_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && upd_bit_mode) |-> ($countones(upd_word ^ old_word) <= 1));

  p_host_read_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_we && !busy) |=> host_rvalid);

  p_host_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && busy) |=> !host_rvalid);
endmodule

bind rma_array rma_array_chk #(.WORD_W(WORD_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_ready     (op_ready),
  .op_bit_mode  (op_bit_mode),
  .op_a_sel     (op_a_sel),
  .op_b_sel     (op_b_sel),
  .busy         (busy),
  .host_en      (host_en),
  .host_we      (host_we),
  .host_rvalid  (host_rvalid),
  .upd_bit_mode (bit_mode_q),
  .upd_word     (upd_word),
  .old_word     (c_q)
);

// File: tb/rma_array_tb_top.sv
module rma_array_tb_top;
  localparam int W  = 8;
  localparam int D  = 4;
  localparam int AW = 2;
  localparam int OW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic          op_ready;
  logic          op_bit_mode = 1'b0;
  logic [1:0]    op_a_sel = '0, op_b_sel = '0;
  logic [AW-1:0] op_a_addr = '0, op_b_addr = '0, op_c_addr = '0;
  logic [OW-1:0] op_a_off = '0, op_b_off = '0, op_c_off = '0;
  logic          busy;
  logic          host_en = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [W-1:0]  host_wdata = '0;
  logic [W-1:0]  host_rdata;
  logic          host_rvalid;

  int n_chk = 0;
  int n_err = 0;
  logic [W-1:0] mdl [D];

  always #4 clk = ~clk;

  rma_array #(.WORD_W(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready), .op_bit_mode(op_bit_mode),
    .op_a_sel(op_a_sel), .op_b_sel(op_b_sel),
    .op_a_addr(op_a_addr), .op_a_off(op_a_off),
    .op_b_addr(op_b_addr), .op_b_off(op_b_off),
    .op_c_addr(op_c_addr), .op_c_off(op_c_off),
    .busy(busy),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
    mdl[a] = d;
  endtask

  task automatic host_rd_check(input string req, input int a);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_addr = AW'(a);
    @(negedge clk);
    host_en = 1'b0;
    check({req, " rvalid"}, W'(host_rvalid), W'(1));
    check(req, host_rdata, mdl[a]);
  endtask

  function automatic logic [W-1:0] src_val(input logic [1:0] s, input bit bm,
                                           input int a, input int o);
    if (s == 2'b00) return '0;
    if (s == 2'b01) return '1;
    if (bm) return {W{mdl[a][o]}};
    return mdl[a];
  endfunction

  // Issues one operation, checks busy timing, updates the model
  task automatic run_op(input bit bm, input logic [1:0] as, input int aa, input int ao,
                        input logic [1:0] bs, input int ba, input int bo,
                        input int ca, input int co);
    logic [W-1:0] av, bv, cv, r, nv;
    av = src_val(as, bm, aa, ao);
    bv = src_val(bs, bm, ba, bo);
    cv = mdl[ca];
    r  = (av & ~bv) | (~bv & cv) | (av & cv);
    nv = cv;
    if (bm) nv[co] = r[co]; else nv = r;
    @(negedge clk);
    op_bit_mode = bm; op_a_sel = as; op_b_sel = bs;
    op_a_addr = AW'(aa); op_a_off = OW'(ao);
    op_b_addr = AW'(ba); op_b_off = OW'(bo);
    op_c_addr = AW'(ca); op_c_off = OW'(co);
    op_valid = 1'b1;
    #1 check("R7 ready idle", W'(op_ready), W'(1));
    @(negedge clk);
    op_valid = 1'b0;
    check("R7 busy after accept", W'(busy), W'(1));
    @(negedge clk);
    check("R7 busy drops", W'(busy), W'(0));
    mdl[ca] = nv;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    check("R10 busy at reset", W'(busy), W'(0));
    for (int i = 0; i < D; i++) host_rd_check("R10 word cleared", i);

    // R9: host preload and readback
    for (int i = 0; i < D; i++) host_wr(i, W'(8'h3C + i * 8'h11));
    for (int i = 0; i < D; i++) host_rd_check("R9 host readback", i);

    // R1/R2/R3: word mode over every selector pair, all bit triples present
    for (int sa = 0; sa < 3; sa++) begin
      for (int sb = 0; sb < 3; sb++) begin
        host_wr(0, 8'hF0); host_wr(1, 8'hCC); host_wr(2, 8'hAA); host_wr(3, 8'h69);
        run_op(1'b0, 2'(sa), 0, 0, 2'(sb), 1, 0, 2, 0);
        host_rd_check("R1 R3 word result", 2);
        host_rd_check("R2 other word kept", 3);
        host_rd_check("R2 source A kept", 0);
      end
    end
    // R3: code 2'b11 also selects the stored operand
    host_wr(2, 8'h5A);
    run_op(1'b0, 2'b11, 0, 0, 2'b11, 1, 0, 2, 0);
    host_rd_check("R3 code 11 stored", 2);

    // R4: clear regardless of old value
    host_wr(3, 8'hA5);
    run_op(1'b0, 2'b00, 0, 0, 2'b01, 0, 0, 3, 0);
    check("R4 model clear", mdl[3], 8'h00);
    host_rd_check("R4 cleared", 3);
    // R5: literal 1 onto cleared word gives ~B
    run_op(1'b0, 2'b01, 0, 0, 2'b10, 1, 0, 3, 0);
    check("R5 model inverse", mdl[3], ~mdl[1]);
    host_rd_check("R5 inverted copy", 3);

    // R8: B and destination alias (old value sampled)
    host_wr(2, 8'h96);
    run_op(1'b0, 2'b01, 0, 0, 2'b10, 2, 0, 2, 0);
    host_rd_check("R8 alias gives ones", 2);
    host_wr(2, 8'h96);
    run_op(1'b0, 2'b00, 0, 0, 2'b10, 2, 0, 2, 0);
    host_rd_check("R8 alias gives zero", 2);
    host_wr(2, 8'h3B);
    run_op(1'b0, 2'b10, 2, 0, 2'b10, 2, 0, 2, 0);
    host_rd_check("R8 full alias keeps", 2);

    // R6: bit mode sweep over all offsets
    host_wr(0, 8'hF0); host_wr(1, 8'hCC); host_wr(2, 8'hAA); host_wr(3, 8'h0F);
    for (int ao = 0; ao < W; ao++) begin
      for (int bo = 0; bo < W; bo++) begin
        for (int co = 0; co < W; co++) begin
          run_op(1'b1, 2'b10, 0, ao, 2'b10, 1, bo, 2, co);
          host_rd_check("R6 bit result", 2);
        end
      end
    end
    host_rd_check("R6 other word kept", 3);
    // R6 with literals in bit mode
    for (int co = 0; co < W; co++) begin
      run_op(1'b1, 2'b00, 0, 0, 2'b01, 0, 0, 3, co);
      host_rd_check("R6 R4 bit clear", 3);
    end
    run_op(1'b1, 2'b01, 0, 0, 2'b10, 1, 2, 3, 5);
    host_rd_check("R6 R5 bit inverse", 3);

    // R7: op_valid while host_en holds ready low and has no effect
    host_wr(2, 8'hE7);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_addr = 2'd0;
    op_valid = 1'b1; op_bit_mode = 1'b0; op_a_sel = 2'b00; op_b_sel = 2'b01;
    op_c_addr = 2'd2;
    #1 check("R7 ready low on host", W'(op_ready), W'(0));
    @(negedge clk);
    host_en = 1'b0; op_valid = 1'b0;
    check("R7 no busy when refused", W'(busy), W'(0));
    host_rd_check("R7 refused op no effect", 2);

    // R9: host write during busy ignored, no rvalid
    host_wr(3, 8'h42);
    @(negedge clk);
    op_bit_mode = 1'b0; op_a_sel = 2'b00; op_b_sel = 2'b01; op_c_addr = 2'd1;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    host_en = 1'b1; host_we = 1'b1; host_addr = 2'd3; host_wdata = 8'hFF;
    check("R9 busy during host try", W'(busy), W'(1));
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
    check("R9 no rvalid when ignored", W'(host_rvalid), W'(0));
    mdl[1] = '0;
    host_rd_check("R9 busy write ignored", 3);
    host_rd_check("R9 op still done", 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule